// File: doc/BRIEF.md
# CAN Node Fault Confinement Unit

This block tracks how reliable a CAN node's view of the bus currently is. It keeps a receive error counter and a transmit error counter. From these it derives one of four confinement states: error active, warning, error passive and bus-off. The protocol engine feeds it single-cycle strobes for receive and transmit errors and for successful frames. It also supplies a bit-boundary tick with the sampled bus level, and strobes for the five frame-error kinds.

A node that has gone bus-off leaves that state without software action. It does so after it has watched 128 runs of 11 consecutive recessive bits. At that point both counters return to zero. Software sees two 32-bit words: a counter word and a status word. The status word carries the state bits and the frame-error flags. A mode input selects whether the state bits follow the live state or hold every state visited until the status word is read. In held mode, a bus-off that has already recovered is still visible. A one-cycle interrupt pulse marks each entry into a new state.

Top module: `can_fault_confine`

## Requirements
- R1: After reset both counters are zero, the state is error active, and `cnt_word` holds the receive count in bits 8:0 and the transmit count in bits 23:16, with all other bits zero.
- R2: A transmit error adds 8 to the transmit count. A receive error adds 1 to the receive count, which saturates at 511. An error strobe takes precedence over a success strobe for the same counter in the same cycle.
- R3: A success strobe lowers the matching counter by 1. A counter at zero stays at zero.
- R4: Exactly one of the four state flags is high. Warning applies when either counter is at least 96, error passive when either counter is at least 128, and bus-off takes precedence over both.
- R5: A transmit error that arrives while the transmit count is 248 or more enters bus-off, and the transmit field then reads 255.
- R6: While the node is bus-off, error and success strobes leave both counters unchanged.
- R7: In bus-off, a recessive bit sampled on a tick extends the current run. A dominant bit on a tick restarts the run at zero. When the 128th run of 11 recessive bits completes, both counters become zero and the state returns to error active.
- R8: `state_irq` pulses for one cycle on entry into a state. Bit 0 means active, bit 1 warning, bit 2 passive and bit 3 bus-off.
- R9: Status word bits 16, 17, 18 and 19 are the active, warning, passive and bus-off bits. With `hold_mode` low they show the current state only.
- R10: With `hold_mode` high, every state visited stays set until a `stat_rd` strobe. After the strobe, only the state that was current during the read cycle remains set, plus any state entered since.
- R11: `frm_err` bits 0 to 4 (CRC, stuff, acknowledge, form, bit) set status word bits 24 to 28 in the same order. These flags hold until `stat_rd`, and a flag raised in the read cycle survives the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_err | input | 1 | Receive error strobe |
| tx_err | input | 1 | Transmit error strobe |
| rx_ok | input | 1 | Successful reception strobe |
| tx_ok | input | 1 | Successful transmission strobe |
| bit_tick | input | 1 | Bit-boundary strobe that qualifies `bit_recessive` |
| bit_recessive | input | 1 | Sampled bus level, 1 means recessive |
| frm_err | input | 5 | Frame-error strobes: CRC, stuff, ack, form, bit |
| hold_mode | input | 1 | 1 holds the state bits until read, 0 shows them live |
| stat_rd | input | 1 | Status word read strobe |
| cnt_word | output | 32 | Counter word |
| stat_word | output | 32 | State bits and frame-error flags |
| st_active | output | 1 | Error active flag |
| st_warn | output | 1 | Warning flag |
| st_passive | output | 1 | Error passive flag |
| st_busoff | output | 1 | Bus-off flag |
| state_irq | output | 4 | One-cycle state entry pulses |

## Verification
The transmit counter is stepped in 8s across 88, 96, 128 and 248 to confirm that each threshold lands on the exact count. The receive counter is driven 520 times so that saturation and receive-driven passive entry are separated from the transmit path. A colliding error and success strobe shows which one wins. Strobes applied while bus-off show that the counters are frozen. The recovery sequence places one dominant bit after ten recessive ones and then runs one recessive bit short of the total, which distinguishes a run that truly restarts from one that only pauses. Held and live state reporting, together with flags that are set and read in the same cycle, separate the latching from the live decode.

// File: rtl/can_fc_pkg.sv
// Shared types and status word layout for the fault confinement unit.
package can_fc_pkg;
    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_WARN    = 2'd1,
        FC_PASSIVE = 2'd2,
        FC_BUSOFF  = 2'd3
    } fc_state_e;

    localparam int NUM_STATES = 4;
    localparam int NUM_FRAME  = 5;
    localparam int RXC_LSB    = 0;
    localparam int TXC_LSB    = 16;
    localparam int STATE_LSB  = 16;
    localparam int FRAME_LSB  = 24;
endpackage

// File: rtl/can_fc_counters.sv
// Receive and transmit error counters with bus-off entry.
// Assumes the strobes are one cycle wide. In bus-off all strobes are
// ignored until recover_done clears both counters.
module can_fc_counters #(
    parameter int RX_W    = 9,
    parameter int TX_W    = 8,
    parameter int TX_STEP = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_err,
    input  logic            tx_err,
    input  logic            rx_ok,
    input  logic            tx_ok,
    input  logic            recover_done,
    output logic [RX_W-1:0] rx_cnt,
    output logic [TX_W-1:0] tx_cnt,
    output logic            busoff
);
    localparam logic [RX_W-1:0] RX_MAX  = {RX_W{1'b1}};
    localparam logic [TX_W-1:0] TX_MAX  = {TX_W{1'b1}};
    localparam logic [TX_W-1:0] TX_INC  = TX_W'(TX_STEP);
    localparam logic [TX_W-1:0] TX_EDGE = TX_MAX - TX_INC + TX_W'(1);

    // Transmit counter and bus-off flag update.
    always_ff @(posedge clk) begin
        if (!rst_n || recover_done) begin
            tx_cnt <= '0;
            busoff <= 1'b0;
        end else if (!busoff) begin
            if (tx_err) begin
                if (tx_cnt >= TX_EDGE) begin
                    tx_cnt <= TX_MAX;
                    busoff <= 1'b1;
                end else begin
                    tx_cnt <= tx_cnt + TX_INC;
                end
            end else if (tx_ok && tx_cnt != '0) begin
                tx_cnt <= tx_cnt - TX_W'(1);
            end
        end
    end

    // Receive counter update, saturating at its maximum.
    always_ff @(posedge clk) begin
        if (!rst_n || recover_done) begin
            rx_cnt <= '0;
        end else if (!busoff) begin
            if (rx_err) begin
                if (rx_cnt != RX_MAX) rx_cnt <= rx_cnt + RX_W'(1);
            end else if (rx_ok && rx_cnt != '0) begin
                rx_cnt <= rx_cnt - RX_W'(1);
            end
        end
    end
endmodule

// File: rtl/can_fc_recovery.sv
// Bus-off recovery sequencer. It counts runs of RUN_LEN recessive bits
// and flags completion on the tick that closes run number RUN_COUNT.
// Assumes bit_recessive is meaningful only when bit_tick is high.
module can_fc_recovery #(
    parameter int RUN_LEN   = 11,
    parameter int RUN_COUNT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busoff,
    input  logic bit_tick,
    input  logic bit_recessive,
    output logic recover_done
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam int SEQ_W = $clog2(RUN_COUNT + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
    localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(RUN_COUNT - 1);

    logic [RUN_W-1:0] run_q;
    logic [SEQ_W-1:0] seq_q;
    logic             run_end;

    assign run_end      = busoff && bit_tick && bit_recessive && (run_q == RUN_LAST);
    assign recover_done = run_end && (seq_q == SEQ_LAST);

    // Run and sequence counters, held at zero outside bus-off.
    always_ff @(posedge clk) begin
        if (!rst_n || !busoff) begin
            run_q <= '0;
            seq_q <= '0;
        end else if (bit_tick) begin
            if (!bit_recessive) begin
                run_q <= '0;
            end else if (run_end) begin
                run_q <= '0;
                seq_q <= seq_q + SEQ_W'(1);
            end else begin
                run_q <= run_q + RUN_W'(1);
            end
        end
    end
endmodule

// File: rtl/can_fc_status.sv
// State decode, entry pulses and status word flags.
// Assumes the counters are registered. The decode is combinational,
// and the held state and frame flags are registered here.
module can_fc_status
    import can_fc_pkg::*;
#(
    parameter int RX_W        = 9,
    parameter int TX_W        = 8,
    parameter int WARN_LIM    = 96,
    parameter int PASSIVE_LIM = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [RX_W-1:0]       rx_cnt,
    input  logic [TX_W-1:0]       tx_cnt,
    input  logic                  busoff,
    input  logic                  hold_mode,
    input  logic                  stat_rd,
    input  logic [NUM_FRAME-1:0]  frm_err,
    output logic [NUM_STATES-1:0] state_oh,
    output logic [NUM_STATES-1:0] state_irq,
    output logic [NUM_STATES-1:0] state_bits,
    output logic [NUM_FRAME-1:0]  frame_bits
);
    localparam logic [RX_W-1:0] RX_WARN = RX_W'(WARN_LIM);
    localparam logic [RX_W-1:0] RX_PASS = RX_W'(PASSIVE_LIM);
    localparam logic [TX_W-1:0] TX_WARN = TX_W'(WARN_LIM);
    localparam logic [TX_W-1:0] TX_PASS = TX_W'(PASSIVE_LIM);

    fc_state_e             cur_state;
    fc_state_e             prev_state;
    logic [NUM_STATES-1:0] held_q;

    // Confinement state from the counters, bus-off first.
    always_comb begin
        if (busoff)
            cur_state = FC_BUSOFF;
        else if (rx_cnt >= RX_PASS || tx_cnt >= TX_PASS)
            cur_state = FC_PASSIVE;
        else if (rx_cnt >= RX_WARN || tx_cnt >= TX_WARN)
            cur_state = FC_WARN;
        else
            cur_state = FC_ACTIVE;
    end

    for (genvar k = 0; k < NUM_STATES; k++) begin : g_state
        assign state_oh[k]  = (cur_state == fc_state_e'(k));
        assign state_irq[k] = state_oh[k] && (prev_state != fc_state_e'(k));
    end

    // Remember last cycle's state for entry detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_state <= FC_ACTIVE;
        else        prev_state <= cur_state;
    end

    // Held state bits: accumulate visits, restart on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)       held_q <= '0;
        else if (stat_rd) held_q <= state_oh;
        else              held_q <= held_q | state_oh;
    end

    // Frame-error flags: set by strobes, cleared by a read.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_bits <= '0;
        else        frame_bits <= (stat_rd ? '0 : frame_bits) | frm_err;
    end

    assign state_bits = hold_mode ? (held_q | state_oh) : state_oh;
endmodule

// File: rtl/can_fault_confine.sv
// Top of the fault confinement unit. It joins the counters, the
// recovery sequencer and the status logic, and packs both words.
module can_fault_confine
    import can_fc_pkg::*;
#(
    parameter int RX_W        = 9,
    parameter int TX_W        = 8,
    parameter int TX_STEP     = 8,
    parameter int WARN_LIM    = 96,
    parameter int PASSIVE_LIM = 128,
    parameter int RUN_LEN     = 11,
    parameter int RUN_COUNT   = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_err,
    input  logic        tx_err,
    input  logic        rx_ok,
    input  logic        tx_ok,
    input  logic        bit_tick,
    input  logic        bit_recessive,
    input  logic [4:0]  frm_err,
    input  logic        hold_mode,
    input  logic        stat_rd,
    output logic [31:0] cnt_word,
    output logic [31:0] stat_word,
    output logic        st_active,
    output logic        st_warn,
    output logic        st_passive,
    output logic        st_busoff,
    output logic [3:0]  state_irq
);
    logic [RX_W-1:0]       rx_cnt;
    logic [TX_W-1:0]       tx_cnt;
    logic                  busoff;
    logic                  recover_done;
    logic [NUM_STATES-1:0] state_oh;
    logic [NUM_STATES-1:0] state_bits;
    logic [NUM_FRAME-1:0]  frame_bits;

    can_fc_counters #(.RX_W(RX_W), .TX_W(TX_W), .TX_STEP(TX_STEP)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .rx_err(rx_err), .tx_err(tx_err), .rx_ok(rx_ok), .tx_ok(tx_ok),
        .recover_done(recover_done),
        .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .busoff(busoff)
    );

    can_fc_recovery #(.RUN_LEN(RUN_LEN), .RUN_COUNT(RUN_COUNT)) u_rec (
        .clk(clk), .rst_n(rst_n), .busoff(busoff),
        .bit_tick(bit_tick), .bit_recessive(bit_recessive),
        .recover_done(recover_done)
    );

    can_fc_status #(.RX_W(RX_W), .TX_W(TX_W), .WARN_LIM(WARN_LIM),
                    .PASSIVE_LIM(PASSIVE_LIM)) u_stat (
        .clk(clk), .rst_n(rst_n),
        .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .busoff(busoff),
        .hold_mode(hold_mode), .stat_rd(stat_rd), .frm_err(frm_err),
        .state_oh(state_oh), .state_irq(state_irq),
        .state_bits(state_bits), .frame_bits(frame_bits)
    );

    // Pack the counter word and the status word.
    always_comb begin
        cnt_word = '0;
        cnt_word[RXC_LSB +: RX_W] = rx_cnt;
        cnt_word[TXC_LSB +: TX_W] = tx_cnt;
        stat_word = '0;
        stat_word[STATE_LSB +: NUM_STATES] = state_bits;
        stat_word[FRAME_LSB +: NUM_FRAME]  = frame_bits;
    end

    assign st_active  = state_oh[FC_ACTIVE];
    assign st_warn    = state_oh[FC_WARN];
    assign st_passive = state_oh[FC_PASSIVE];
    assign st_busoff  = state_oh[FC_BUSOFF];
endmodule

// File: rtl/can_fc_checker.sv
// Temporal checks on the unit's ports, bound into every instance.
module can_fc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_err,
    input logic        tx_err,
    input logic        bit_tick,
    input logic [4:0]  frm_err,
    input logic [31:0] cnt_word,
    input logic [31:0] stat_word,
    input logic        st_active,
    input logic        st_warn,
    input logic        st_passive,
    input logic        st_busoff,
    input logic [3:0]  state_irq
);
    AST_TX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err && !st_busoff && cnt_word[23:16] < 8'd248)
        |=> cnt_word[23:16] == $past(cnt_word[23:16]) + 8'd8); // R2

    AST_RX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_err && !st_busoff && cnt_word[8:0] != 9'd511)
        |=> cnt_word[8:0] == $past(cnt_word[8:0]) + 9'd1); // R2

    AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({st_busoff, st_passive, st_warn, st_active})); // R4

    AST_BUSOFF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err && !st_busoff && cnt_word[23:16] >= 8'd248)
        |=> st_busoff && cnt_word[23:16] == 8'd255); // R5

    AST_BUSOFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_busoff && !bit_tick) |=> $stable(cnt_word)); // R6

    AST_RECOVER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_busoff) |-> (cnt_word == 32'd0 && st_active)); // R7

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(state_irq)); // R8

    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (|frm_err) |=> (stat_word[28:24] & $past(frm_err)) == $past(frm_err)); // R11
endmodule

bind can_fault_confine can_fc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rx_err(rx_err), .tx_err(tx_err),
    .bit_tick(bit_tick), .frm_err(frm_err), .cnt_word(cnt_word),
    .stat_word(stat_word), .st_active(st_active), .st_warn(st_warn),
    .st_passive(st_passive), .st_busoff(st_busoff), .state_irq(state_irq)
);

// File: tb/can_fault_confine_test.sv
module can_fault_confine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_err = 0, tx_err = 0, rx_ok = 0, tx_ok = 0;
    logic        bit_tick = 0, bit_recessive = 0;
    logic [4:0]  frm_err = '0;
    logic        hold_mode = 0, stat_rd = 0;
    logic [31:0] cnt_word, stat_word;
    logic        st_active, st_warn, st_passive, st_busoff;
    logic [3:0]  state_irq;

    int vectors = 0;
    int misses  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    can_fault_confine uut (
        .clk(clk), .rst_n(rst_n), .rx_err(rx_err), .tx_err(tx_err),
        .rx_ok(rx_ok), .tx_ok(tx_ok), .bit_tick(bit_tick),
        .bit_recessive(bit_recessive), .frm_err(frm_err),
        .hold_mode(hold_mode), .stat_rd(stat_rd), .cnt_word(cnt_word),
        .stat_word(stat_word), .st_active(st_active), .st_warn(st_warn),
        .st_passive(st_passive), .st_busoff(st_busoff), .state_irq(state_irq)
    );

    // Behavioural reference model.
    int       m_rx = 0, m_tx = 0, m_run = 0, m_seq = 0, m_prev = 0, m_cur = 0;
    bit       m_bo = 0, m_done = 0;
    bit [3:0] m_held = '0;
    bit [4:0] m_ff = '0;

    function automatic int state_of();
        if (m_bo) return 3;
        if (m_rx >= 128 || m_tx >= 128) return 2;
        if (m_rx >= 96 || m_tx >= 96) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rx = 0; m_tx = 0; m_run = 0; m_seq = 0; m_prev = 0;
            m_bo = 0; m_held = '0; m_ff = '0;
        end else begin
            m_cur = state_of();
            if (stat_rd) m_held = 4'(1 << m_cur);
            else         m_held = m_held | 4'(1 << m_cur);
            m_ff = (stat_rd ? 5'd0 : m_ff) | frm_err;
            m_prev = m_cur;
            m_done = 0;
            if (m_bo) begin
                if (bit_tick) begin
                    if (!bit_recessive) m_run = 0;
                    else if (m_run == 10) begin
                        m_run = 0;
                        if (m_seq == 127) m_done = 1;
                        m_seq++;
                    end else m_run++;
                end
            end else begin
                m_run = 0; m_seq = 0;
            end
            if (m_done) begin
                m_rx = 0; m_tx = 0; m_bo = 0;
            end else if (!m_bo) begin
                if (tx_err) begin
                    if (m_tx >= 248) begin m_tx = 255; m_bo = 1; end
                    else m_tx += 8;
                end else if (tx_ok && m_tx > 0) m_tx--;
                if (rx_err) begin
                    if (m_rx < 511) m_rx++;
                end else if (rx_ok && m_rx > 0) m_rx--;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare outputs against the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            automatic int s = state_of();
            automatic logic [3:0] oh = 4'(1 << s);
            automatic logic [3:0] sb = hold_mode ? (m_held | oh) : oh;
            chk("R1 R2 R3 R5 R6 R7 cnt_word", cnt_word, 32'((m_tx << 16) | m_rx));
            chk("R9 R10 R11 stat_word", stat_word, {3'b0, m_ff, 4'b0, sb, 16'b0});
            chk("R4 flags", {28'b0, st_busoff, st_passive, st_warn, st_active}, {28'b0, oh});
            chk("R8 state_irq", {28'b0, state_irq}, {28'b0, (s != m_prev) ? oh : 4'b0});
        end
    end

    task automatic ev(input bit re, input bit te, input bit ro, input bit to_);
        rx_err = re; tx_err = te; rx_ok = ro; tx_ok = to_;
        @(negedge clk);
        rx_err = 0; tx_err = 0; rx_ok = 0; tx_ok = 0;
    endtask

    task automatic tick(input bit rec);
        bit_tick = 1; bit_recessive = rec;
        @(negedge clk);
        bit_tick = 0; bit_recessive = 0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset counters", cnt_word, 32'h0);
        chk("R9 reset status", stat_word, 32'h0001_0000);

        for (int i = 0; i < 5; i++) ev(1, 0, 0, 0);
        for (int i = 0; i < 3; i++) ev(0, 1, 0, 0);
        chk("R2 error steps", cnt_word, 32'h0018_0005);
        ev(1, 0, 1, 0);
        chk("R2 error wins over success", cnt_word, 32'h0018_0006);
        for (int i = 0; i < 8; i++) ev(0, 0, 1, 0);
        for (int i = 0; i < 8; i++) ev(0, 0, 0, 1);
        chk("R3 floor at zero", cnt_word, 32'h0010_0000);

        for (int i = 0; i < 9; i++) ev(0, 1, 0, 0);
        chk("R4 88 still active", {31'b0, st_active}, 32'd1);
        ev(0, 1, 0, 0);
        chk("R4 warn at 96", {31'b0, st_warn}, 32'd1);
        chk("R8 warn pulse", {28'b0, state_irq}, 32'h2);
        for (int i = 0; i < 4; i++) ev(0, 1, 0, 0);
        chk("R4 passive at 128", {31'b0, st_passive}, 32'd1);
        chk("R9 passive bit", stat_word, 32'h0004_0000);

        for (int i = 0; i < 15; i++) ev(0, 1, 0, 0);
        chk("R5 248 not bus-off", {31'b0, st_busoff}, 32'd0);
        ev(0, 1, 0, 0);
        chk("R5 bus-off count", cnt_word, 32'h00FF_0000);
        chk("R8 bus-off pulse", {28'b0, state_irq}, 32'h8);

        ev(1, 0, 0, 0);
        ev(0, 1, 0, 0);
        ev(0, 0, 1, 1);
        chk("R6 strobes ignored", cnt_word, 32'h00FF_0000);

        hold_mode = 1;
        for (int i = 0; i < 10; i++) tick(1);
        tick(0);
        for (int i = 0; i < 127 * 11 + 10; i++) tick(1);
        chk("R7 dominant restarts run", {31'b0, st_busoff}, 32'd1);
        tick(1);
        chk("R7 recovered counters", cnt_word, 32'h0);
        chk("R7 recovered active", {31'b0, st_active}, 32'd1);
        chk("R10 bus-off held", {31'b0, stat_word[19]}, 32'd1);
        stat_rd = 1;
        @(negedge clk);
        stat_rd = 0;
        chk("R10 cleared by read", {28'b0, stat_word[19:16]}, 32'h1);

        frm_err = 5'b00101;
        @(negedge clk);
        frm_err = 5'b10000;
        stat_rd = 1;
        @(negedge clk);
        frm_err = 5'b0;
        stat_rd = 0;
        chk("R11 flags across read", {27'b0, stat_word[28:24]}, 32'h10);
        stat_rd = 1;
        @(negedge clk);
        stat_rd = 0;
        chk("R11 flags cleared", {27'b0, stat_word[28:24]}, 32'h0);

        for (int i = 0; i < 520; i++) ev(1, 0, 0, 0);
        chk("R2 rx saturates", cnt_word, 32'h0000_01FF);
        hold_mode = 0;
        @(negedge clk);
        chk("R4 R9 live passive from rx", {28'b0, stat_word[19:16]}, 32'h4);
        for (int i = 0; i < 3; i++) ev(0, 0, 1, 0);
        chk("R3 rx decrements", cnt_word, 32'h0000_01FC);

        finish_run();
    end
endmodule